// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block holds two 32-bit state vectors for an interrupt controller: an enable vector and a pending vector. Software changes either vector through a pair of address aliases. A write to the set alias turns on every bit where the write data holds a 1. A write to the clear alias turns off every bit where the write data holds a 1. A 0 in the write data leaves that bit as it was. A read of either alias of a vector returns the live contents of that vector, never the value last written.

Hardware request lines can also raise pending bits. The block drives a request vector that is the bitwise AND of enable and pending, delayed by one register. The bus port is a plain single-cycle register interface with no handshake. A write takes effect at the clock edge on which the write strobe is sampled. Read data is combinational from the address. The data width equals the number of interrupt lines (default 32). Choosing a winner among requests, looking up vectors and entering exceptions are left to other blocks.

Top module: `irq_enable_bank`

## Requirements
- R1: A write to offset 0x100 (enable-set) sets each enable bit whose write-data bit is 1 and leaves the other bits unchanged. An all-zero write changes nothing.
- R2: A write to offset 0x180 (enable-clear) clears each enable bit whose write-data bit is 1 and leaves the other bits unchanged. An all-zero write changes nothing.
- R3: Reads at 0x100 and at 0x180 both return the current enable vector, bit n for line n.
- R4: The last write decides the result. Setting bit 19 and then clearing it leaves it 0. Clearing it and then setting it leaves it 1.
- R5: Offsets 0x200 (pending-set) and 0x280 (pending-clear) act on the pending vector under the same set and clear rules. Reads at either offset return the current pending vector.
- R6: When irq_lines bit n is 1 at a clock edge, pending bit n becomes 1. If a pending-clear write of that bit falls on the same edge, the bit still ends up 1.
- R7: After reset, the enable vector, the pending vector and irq_req are all zero.
- R8: A read at any offset other than the four listed returns zero. A write to any such offset changes neither vector.
- R9: irq_req equals enable AND pending as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | NUM_IRQ (32) | Write data, one bit per line |
| bus_rdata | output | NUM_IRQ (32) | Read data for bus_addr, combinational |
| irq_lines | input | NUM_IRQ (32) | Hardware request lines that raise pending bits |
| irq_req | output | NUM_IRQ (32) | Registered enable AND pending |

## Verification
The assertions assume that bus_addr, bus_wr, bus_wdata and irq_lines carry known values from reset release onward, and that each write lasts exactly one sampled edge. The clear-side properties discount bits that irq_lines raises on the same edge. The hold property on the pending vector applies only to cycles with no write and all request lines low. The stimulus changes inputs only on falling clock edges and returns the strobe, the address and the request lines to zero between operations, which keeps every sampled edge inside these assumptions.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    // Register offsets; the decoder and the readback mux both depend on them.
    localparam int OFS_EN_SET = 'h100;
    localparam int OFS_EN_CLR = 'h180;
    localparam int OFS_PD_SET = 'h200;
    localparam int OFS_PD_CLR = 'h280;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_EN_SET = 3'd1,
        SEL_EN_CLR = 3'd2,
        SEL_PD_SET = 3'd3,
        SEL_PD_CLR = 3'd4
    } bank_sel_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output bank_sel_e         sel
);

    localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFS_EN_CLR);
    localparam logic [ADDR_W-1:0] A_PD_SET = ADDR_W'(OFS_PD_SET);
    localparam logic [ADDR_W-1:0] A_PD_CLR = ADDR_W'(OFS_PD_CLR);

    always_comb begin
        unique case (addr)
            A_EN_SET: sel = SEL_EN_SET;
            A_EN_CLR: sel = SEL_EN_CLR;
            A_PD_SET: sel = SEL_PD_SET;
            A_PD_CLR: sel = SEL_PD_CLR;
            default:  sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/irq_w1sc_vector.sv
module irq_w1sc_vector #(
    parameter int WIDTH  = 32,
    parameter bit HW_SET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_mask,
    input  logic [WIDTH-1:0] clr_mask,
    input  logic [WIDTH-1:0] hw_set,
    output logic [WIDTH-1:0] state_q
);

    logic [WIDTH-1:0] state_d;

    generate
        if (HW_SET) begin : g_hw
            // Hardware raise is OR-ed last, so it beats a same-cycle clear.
            assign state_d = (state_q & ~clr_mask) | set_mask | hw_set;
        end else begin : g_sw
            logic unused_hw;
            assign unused_hw = ^hw_set;
            assign state_d = (state_q & ~clr_mask) | set_mask;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [NUM_IRQ-1:0] bus_wdata,
    output logic [NUM_IRQ-1:0] bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_lines,
    output logic [NUM_IRQ-1:0] irq_req
);

    bank_sel_e          sel;
    logic [NUM_IRQ-1:0] en_q;
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] en_set;
    logic [NUM_IRQ-1:0] en_clr;
    logic [NUM_IRQ-1:0] pd_set;
    logic [NUM_IRQ-1:0] pd_clr;

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb begin
        en_set = (bus_wr && sel == SEL_EN_SET) ? bus_wdata : '0;
        en_clr = (bus_wr && sel == SEL_EN_CLR) ? bus_wdata : '0;
        pd_set = (bus_wr && sel == SEL_PD_SET) ? bus_wdata : '0;
        pd_clr = (bus_wr && sel == SEL_PD_CLR) ? bus_wdata : '0;
    end

    irq_w1sc_vector #(.WIDTH(NUM_IRQ), .HW_SET(1'b0)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (en_set),
        .clr_mask (en_clr),
        .hw_set   ('0),
        .state_q  (en_q)
    );

    irq_w1sc_vector #(.WIDTH(NUM_IRQ), .HW_SET(1'b1)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (pd_set),
        .clr_mask (pd_clr),
        .hw_set   (irq_lines),
        .state_q  (pend_q)
    );

    // Both aliases of a vector return live state.
    always_comb begin
        unique case (sel)
            SEL_EN_SET, SEL_EN_CLR: bus_rdata = en_q;
            SEL_PD_SET, SEL_PD_CLR: bus_rdata = pend_q;
            default:                bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_req <= '0;
        end else begin
            irq_req <= en_q & pend_q;
        end
    end

endmodule

// File: rtl/irq_enable_bank_chk.sv
module irq_enable_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [NUM_IRQ-1:0] bus_wdata,
    input logic [NUM_IRQ-1:0] bus_rdata,
    input logic [NUM_IRQ-1:0] irq_lines,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic [NUM_IRQ-1:0] en_q,
    input logic [NUM_IRQ-1:0] pend_q
);

    localparam logic [ADDR_W-1:0] A_ES = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_EC = ADDR_W'(OFS_EN_CLR);
    localparam logic [ADDR_W-1:0] A_PS = ADDR_W'(OFS_PD_SET);
    localparam logic [ADDR_W-1:0] A_PC = ADDR_W'(OFS_PD_CLR);

    logic mapped;
    assign mapped = (bus_addr == A_ES) || (bus_addr == A_EC) ||
                    (bus_addr == A_PS) || (bus_addr == A_PC);

    assert_en_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ES) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_en_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr) |=> $stable(en_q));

    assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EC) |=> ((en_q & $past(bus_wdata)) == '0));

    assert_alias_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_ES || bus_addr == A_EC) |-> (bus_rdata == en_q));

    assert_pd_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_PS) |=> ((pend_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_pd_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_PC) |=>
        ((pend_q & $past(bus_wdata) & ~$past(irq_lines)) == '0));

    assert_pd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && irq_lines == '0) |=> $stable(pend_q));

    assert_hw_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines != '0) |=> ((pend_q & $past(irq_lines)) == $past(irq_lines)));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mapped) |-> (bus_rdata == '0));

    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped && irq_lines == '0) |=> ($stable(en_q) && $stable(pend_q)));

    assert_gated_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_req == ($past(en_q) & $past(pend_q))));

endmodule

bind irq_enable_bank irq_enable_bank_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_lines (irq_lines),
    .irq_req   (irq_req),
    .en_q      (en_q),
    .pend_q    (pend_q)
);

// File: tb/test_irq_enable_bank.sv
module test_irq_enable_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_lines = '0;
    logic [31:0] irq_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    irq_enable_bank i_irq_enable_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lines (irq_lines),
        .irq_req   (irq_req)
    );

    // {offset, write data, expected enable vector after the write}
    localparam logic [75:0] STEPS [10] = '{
        {12'h100, 32'h0000_0000, 32'h0000_0000},  // R1 zero write
        {12'h180, 32'h0008_0000, 32'h0000_0000},  // R2 clear of clear bit
        {12'h100, 32'h0008_0000, 32'h0008_0000},  // R4 set bit 19
        {12'h180, 32'h0008_0000, 32'h0000_0000},  // R4 then clear
        {12'h180, 32'h0000_0000, 32'h0000_0000},  // R2 zero write
        {12'h100, 32'h0008_0000, 32'h0008_0000},  // R4 clear then set
        {12'h100, 32'hF000_000F, 32'hF008_000F},  // R1 others kept
        {12'h180, 32'h0000_000F, 32'hF008_0000},  // R2 partial clear
        {12'h100, 32'h0000_0000, 32'hF008_0000},  // R1 zero write
        {12'h104, 32'hFFFF_FFFF, 32'hF008_0000}   // R8 unmapped write
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
        bus_addr  = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
        bus_addr = '0;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        bus_read(12'h100, rd); check("R7 enable after reset", rd, 32'h0);
        bus_read(12'h200, rd); check("R7 pending after reset", rd, 32'h0);
        check("R7 irq_req after reset", irq_req, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 10; i++) begin
            bus_write(STEPS[i][75:64], STEPS[i][63:32]);
            bus_read(12'h100, rd);
            check($sformatf("R1/R2/R4/R8 step %0d set alias", i), rd, STEPS[i][31:0]);
            bus_read(12'h180, rd);
            check($sformatf("R3 step %0d clear alias", i), rd, STEPS[i][31:0]);
        end

        // R5: pending aliases
        bus_write(12'h200, 32'h0000_0005);
        bus_read(12'h280, rd); check("R5 pending set read at clear alias", rd, 32'h5);
        bus_write(12'h280, 32'h0000_0001);
        bus_read(12'h200, rd); check("R5 pending clear", rd, 32'h4);
        bus_read(12'h280, rd); check("R5 pending aliases agree", rd, 32'h4);
        check("R9 no overlap", irq_req, 32'h0);

        // R9: one-cycle latency
        bus_write(12'h100, 32'h0000_0004);
        check("R9 request not yet visible", irq_req, 32'h0);
        @(negedge clk);
        check("R9 request after one cycle", irq_req, 32'h4);

        // R6: hardware raise beats a same-edge clear
        irq_lines = 32'h0000_0100;
        bus_write(12'h280, 32'h0000_0104);
        irq_lines = '0;
        bus_read(12'h200, rd); check("R6 hw set wins over clear", rd, 32'h100);
        irq_lines = 32'h0000_1000;
        @(negedge clk);
        irq_lines = '0;
        bus_read(12'h200, rd); check("R6 hw pulse alone", rd, 32'h1100);
        @(negedge clk);
        check("R9 enable bit 2 cleared pending", irq_req, 32'h0);

        // R8: unmapped offsets
        bus_read(12'h300, rd); check("R8 unmapped read 0x300", rd, 32'h0);
        bus_read(12'h000, rd); check("R8 unmapped read 0x000", rd, 32'h0);
        bus_write(12'h204, 32'hFFFF_FFFF);
        bus_read(12'h200, rd); check("R8 pending kept after unmapped write", rd, 32'h1100);
        bus_read(12'h100, rd); check("R8 enable kept after unmapped write", rd, 32'hF008_0004);

        // R9: overlap appears one cycle after the enable write
        bus_write(12'h100, 32'h0000_0100);
        check("R9 still old", irq_req, 32'h0);
        @(negedge clk);
        check("R9 bit 8 requested", irq_req, 32'h100);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule